// File: doc/BRIEF.md
# Iterative Integer Divider with Zero-Divisor Trap

This block computes the quotient of two integers for a processor execute stage, one bit per clock, using a shift-and-subtract restoring loop. A one-cycle `start_i` pulse launches a division of `a_i` by `b_i`. `signed_i` selects two's-complement or plain binary operands. `busy_o` stays high while the loop runs. A single-cycle `done_o` pulse marks a valid `quot_o`, and `quot_o` holds its value until the next division finishes.

A zero divisor is detected when `start_i` is sampled, and no iterations are run for it. The result is forced to zero and done comes back on the next edge. A status strobe is pulsed so that the surrounding core can set its sticky divide-by-zero flag. The strobe fires whether or not a trap follows. The hardware exception request and its cause code are raised only when the core's exception-enable bit is set and the divide-by-zero trap option is configured on. Both enables are sampled together with `start_i`.

Top module: `int_div_trap`

## Requirements
- R1: In unsigned mode (`signed_i`=0), `quot_o` equals floor(a/b), with a and b read as unsigned WIDTH-bit values.
- R2: In signed mode (`signed_i`=1), a and b are read as two's-complement WIDTH-bit values and `quot_o` is the quotient truncated toward zero, returned as WIDTH bits.
- R3: In signed mode, the most negative value divided by -1 returns the most negative value. `dz_set_o` and `exc_req_o` stay low in this case.
- R4: With `b_i`=0, `done_o` is high right after the edge that samples `start_i`, and `quot_o` is 0.
- R5: `dz_set_o` is high together with `done_o` for every zero divisor, whatever the enables are. It is never high for a nonzero divisor.
- R6: `exc_req_o` is high with `done_o` only when the divisor is zero and both `ee_i` and `trap_cfg_i` were 1 at start.
- R7: `cause_o` is 5 (5 bits) while `exc_req_o` is high and 0 otherwise.
- R8: For a nonzero divisor, `done_o` rises WIDTH+2 clock edges after the start sample, counting the sampling edge. `busy_o` is high in between, and `busy_o` and `done_o` are never high together.
- R9: `start_i` asserted while `busy_o` is high is ignored. The running division completes with its original operands and latency.
- R10: After reset, `busy_o`, `done_o`, `dz_set_o` and `exc_req_o` are 0, and `quot_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch pulse, taken only when idle |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| a_i | input | WIDTH | Dividend |
| b_i | input | WIDTH | Divisor |
| ee_i | input | 1 | Exception-enable status bit of the core |
| trap_cfg_i | input | 1 | Divide-by-zero trap configured on |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| quot_o | output | WIDTH | Quotient, held until the next completion |
| dz_set_o | output | 1 | Strobe to set the sticky divide-by-zero flag |
| exc_req_o | output | 1 | Hardware exception request |
| cause_o | output | CAUSE_W | Exception cause code |

## Verification
A zero-divisor result is due on the edge that samples the start pulse. A nonzero-divisor result is due WIDTH+2 edges after that sampling edge. The bench drives inputs on falling edges and counts each rising edge until it sees `done_o`. It compares that count with the expected latency, then checks the quotient, status strobe, request and cause in that same half-cycle, because they are valid only while `done_o` is high. A 6-bit instance is swept over every operand pair in both modes, and the zero-divisor cases rotate through all four enable combinations.

// File: rtl/div_trap_pkg.sv
package div_trap_pkg;
    typedef enum logic [1:0] {
        DV_IDLE = 2'd0,
        DV_RUN  = 2'd1,
        DV_FIX  = 2'd2
    } dv_state_e;
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] val_i,
    input  logic             is_signed_i,
    output logic [WIDTH-1:0] mag_o,
    output logic             neg_o
);
    always_comb begin
        neg_o = is_signed_i & val_i[WIDTH-1];
        mag_o = neg_o ? (~val_i + 1'b1) : val_i;
    end
endmodule

// File: rtl/div_restore_step.sv
module div_restore_step #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] rem_i,
    input  logic [WIDTH-1:0] quo_i,
    input  logic [WIDTH-1:0] dvs_i,
    output logic [WIDTH-1:0] rem_o,
    output logic [WIDTH-1:0] quo_o
);
    logic [WIDTH:0] trial;
    logic [WIDTH:0] diff;
    logic           fits;

    always_comb begin
        trial = {rem_i, quo_i[WIDTH-1]};
        diff  = trial - {1'b0, dvs_i};
        fits  = ~diff[WIDTH];
        rem_o = fits ? diff[WIDTH-1:0] : trial[WIDTH-1:0];
        quo_o = {quo_i[WIDTH-2:0], fits};
    end
endmodule

// File: rtl/div_trap_eval.sv
module div_trap_eval #(
    parameter int          CAUSE_W    = 5,
    parameter int unsigned CAUSE_CODE = 5
) (
    input  logic               zero_i,
    input  logic               ee_i,
    input  logic               cfg_i,
    output logic               set_o,
    output logic               trap_o,
    output logic [CAUSE_W-1:0] cause_o
);
    always_comb begin
        set_o   = zero_i;
        trap_o  = zero_i & ee_i & cfg_i;
        cause_o = trap_o ? CAUSE_W'(CAUSE_CODE) : '0;
    end
endmodule

// File: rtl/int_div_trap.sv
module int_div_trap
    import div_trap_pkg::*;
#(
    parameter int          WIDTH      = 32,
    parameter int          CAUSE_W    = 5,
    parameter int unsigned CAUSE_CODE = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               signed_i,
    input  logic [WIDTH-1:0]   a_i,
    input  logic [WIDTH-1:0]   b_i,
    input  logic               ee_i,
    input  logic               trap_cfg_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [WIDTH-1:0]   quot_o,
    output logic               dz_set_o,
    output logic               exc_req_o,
    output logic [CAUSE_W-1:0] cause_o
);
    localparam int CNT_W = $clog2(WIDTH + 1);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

    typedef struct packed {
        dv_state_e          st;
        logic [CNT_W-1:0]   cnt;
        logic [WIDTH-1:0]   rem;
        logic [WIDTH-1:0]   quo;
        logic [WIDTH-1:0]   dvs;
        logic               neg;
        logic               busy;
        logic               done;
        logic [WIDTH-1:0]   result;
        logic               dz;
        logic               exc;
        logic [CAUSE_W-1:0] cause;
    } dv_regs_t;

    dv_regs_t r_q, r_d;

    logic [WIDTH-1:0]   a_mag, b_mag, step_rem, step_quo;
    logic               a_neg, b_neg, b_zero, t_set, t_trap;
    logic [CAUSE_W-1:0] t_cause;

    div_operand_prep #(.WIDTH(WIDTH)) u_prep_a (
        .val_i(a_i), .is_signed_i(signed_i), .mag_o(a_mag), .neg_o(a_neg)
    );
    div_operand_prep #(.WIDTH(WIDTH)) u_prep_b (
        .val_i(b_i), .is_signed_i(signed_i), .mag_o(b_mag), .neg_o(b_neg)
    );
    div_restore_step #(.WIDTH(WIDTH)) u_step (
        .rem_i(r_q.rem), .quo_i(r_q.quo), .dvs_i(r_q.dvs),
        .rem_o(step_rem), .quo_o(step_quo)
    );

    assign b_zero = (b_i == '0);

    div_trap_eval #(.CAUSE_W(CAUSE_W), .CAUSE_CODE(CAUSE_CODE)) u_trap (
        .zero_i(b_zero), .ee_i(ee_i), .cfg_i(trap_cfg_i),
        .set_o(t_set), .trap_o(t_trap), .cause_o(t_cause)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.dz    = 1'b0;
        r_d.exc   = 1'b0;
        r_d.cause = '0;
        unique case (r_q.st)
            DV_IDLE: begin
                if (start_i) begin
                    if (b_zero) begin
                        r_d.done   = 1'b1;
                        r_d.result = '0;
                        r_d.dz     = t_set;
                        r_d.exc    = t_trap;
                        r_d.cause  = t_cause;
                    end else begin
                        r_d.st   = DV_RUN;
                        r_d.busy = 1'b1;
                        r_d.cnt  = '0;
                        r_d.rem  = '0;
                        r_d.quo  = a_mag;
                        r_d.dvs  = b_mag;
                        r_d.neg  = a_neg ^ b_neg;
                    end
                end
            end
            DV_RUN: begin
                r_d.rem = step_rem;
                r_d.quo = step_quo;
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == LAST_STEP) begin
                    r_d.st = DV_FIX;
                end
            end
            DV_FIX: begin
                r_d.result = r_q.neg ? (~r_q.quo + 1'b1) : r_q.quo;
                r_d.done   = 1'b1;
                r_d.busy   = 1'b0;
                r_d.st     = DV_IDLE;
            end
            default: begin
                r_d.st   = DV_IDLE;
                r_d.busy = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: DV_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o    = r_q.busy;
    assign done_o    = r_q.done;
    assign quot_o    = r_q.result;
    assign dz_set_o  = r_q.dz;
    assign exc_req_o = r_q.exc;
    assign cause_o   = r_q.cause;

    assert_busy_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));
    assert_zero_fast_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && b_i == '0) |=> (done_o && quot_o == '0));
    assert_dz_always_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && b_i == '0) |=> dz_set_o);
    assert_dz_only_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dz_set_o |-> done_o);
    assert_trap_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !(ee_i && trap_cfg_i)) |=> !exc_req_o);
    assert_trap_implies_dz_R6: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req_o |-> dz_set_o);
    assert_cause_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req_o |-> cause_o == CAUSE_W'(CAUSE_CODE));
    assert_cause_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_req_o |-> cause_o == '0);
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (busy_o || done_o) && !dz_set_o);
endmodule

// File: tb/tb_int_div_trap.sv
module tb_int_div_trap;
    localparam int W = 6;
    localparam int NZ_LAT = W + 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0, signed_i = 1'b0, ee_i = 1'b0, trap_cfg_i = 1'b0;
    logic [W-1:0] a_i = '0, b_i = '0;
    logic         busy_o, done_o, dz_set_o, exc_req_o;
    logic [W-1:0] quot_o;
    logic [4:0]   cause_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    int_div_trap #(.WIDTH(W), .CAUSE_W(5), .CAUSE_CODE(5)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
        .a_i(a_i), .b_i(b_i), .ee_i(ee_i), .trap_cfg_i(trap_cfg_i),
        .busy_o(busy_o), .done_o(done_o), .quot_o(quot_o),
        .dz_set_o(dz_set_o), .exc_req_o(exc_req_o), .cause_o(cause_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int expect_q(input bit sg, input int a, input int b);
        int sa, sb, q;
        if (b == 0) return 0;
        if (sg) begin
            sa = (a >= (1 << (W-1))) ? a - (1 << W) : a;
            sb = (b >= (1 << (W-1))) ? b - (1 << W) : b;
            q  = sa / sb;
        end else begin
            q = a / b;
        end
        return q & ((1 << W) - 1);
    endfunction

    task automatic run_op(input bit sg, input int a, input int b, input bit ee, input bit cfg,
                          input bit poke);
        int lat;
        string rq;
        bit zero, trap;
        @(negedge clk);
        signed_i = sg; a_i = W'(a); b_i = W'(b); ee_i = ee; trap_cfg_i = cfg; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 100) begin
            if (poke && lat == 3) begin
                a_i = '1; b_i = '0; ee_i = 1'b1; trap_cfg_i = 1'b1; start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start_i = 1'b0;
        zero = (b == 0);
        trap = zero && ee && cfg;
        rq = zero ? "R4" : (sg ? "R2" : "R1");
        if (poke) rq = "R9";
        else if (sg && a == (1 << (W-1)) && b == ((1 << W) - 1)) rq = "R3";
        check(zero ? "R4" : "R8", "latency", lat, zero ? 1 : NZ_LAT);
        check(rq, "quotient", int'(quot_o), expect_q(sg, a, b));
        check(rq == "R3" ? "R3" : "R5", "dz_set", int'(dz_set_o), int'(zero));
        check(rq == "R3" ? "R3" : "R6", "exc_req", int'(exc_req_o), int'(trap));
        check("R7", "cause", int'(cause_o), trap ? 5 : 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10", "busy", int'(busy_o), 0);
        check("R10", "done", int'(done_o), 0);
        check("R10", "quot", int'(quot_o), 0);
        check("R10", "dz_set", int'(dz_set_o), 0);
        check("R10", "exc_req", int'(exc_req_o), 0);
        rst_n = 1'b1;
        // R3: most negative by -1 in signed mode
        run_op(1'b1, 1 << (W-1), (1 << W) - 1, 1'b1, 1'b1, 1'b0);
        // R9: start pulse with a zero divisor while busy must be ignored
        run_op(1'b0, 45, 7, 1'b0, 1'b0, 1'b1);
        run_op(1'b1, 50, 3, 1'b1, 1'b0, 1'b1);
        // R1, R2, R4-R7: full sweep in both modes, enables rotate on zero divisors
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < (1 << W); a++) begin
                for (int b = 0; b < (1 << W); b++) begin
                    run_op(m[0], a, b, a[0], a[1], 1'b0);
                end
            end
        end
        finished = 1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!finished && cyc < 190000) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d cycles expected=completion", cyc);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule